// File: doc/BRIEF.md
# Branch and Skip Next-Address Unit

This unit works out the program counter that follows a conditional control-transfer instruction in a small 8-bit processor with a 16-bit address space. The caller presents the instruction's low nibble, a flag that selects the one-byte (short) or two-byte (long) form, and the PC, which already points at the first operand byte. It also presents the condition sources: the output latch Q, the accumulator, the carry flag, the interrupt-enable flag and four external sense flags. The unit then returns the new PC together with a registered taken/not-taken decision.

A short branch that is taken keeps the PC's page and replaces only the low byte with the operand. A short branch that is not taken steps over the operand. A long branch that is taken reads two operand bytes, the high byte first. The high byte is held in an internal byte register while the PC advances, and then both bytes form the full target. A long branch that is not taken steps over both bytes. Long skips never jump. When the condition holds they step the PC by two, and otherwise they leave it untouched. The unit fetches operand bytes through a plain byte-read port with a request/acknowledge pair and makes its internal sub-steps one per clock.

Every condition input is sampled in the cycle that `start` is accepted. A build-time switch ties the four external flags to all ones when no source is wired.

Top module: `jump_target_unit`

## Requirements
- R1: After reset `busy`, `done`, `mem_req`, `taken` are 0 and `pc_out` is 0.
- R2: Short form (`is_long`=0): nibble 0 always branches, 1 when Q=1, 2 when acc=0, 3 when carry=1; nibbles 8, 9, A, B use the opposite conditions (never, Q=0, acc≠0, carry=0).
- R3: Short form nibbles 4 to 7 branch when external flag `ext_flags[nib[1:0]]` is 0 and nibbles C to F when that flag is 1 (bit 0 is the first flag); all condition inputs are taken from the cycle `start` is accepted, so later changes have no effect.
- R4: A taken short branch yields `{pc_in[15:8], byte at pc_in}`; a short branch not taken yields `pc_in + 1`.
- R5: Long form branches: nibble 0 always, 1 on Q=1, 2 on acc=0, 3 on carry=1, 9 on Q=0, A on acc≠0, B on carry=0; taken yields `{byte at pc_in, byte at pc_in+1}`, not taken yields `pc_in + 2`.
- R6: Long form skips: 5 on Q=0, 6 on acc≠0, 7 on carry=0, 8 always, C on interrupt-enable=1, D on Q=1, E on acc=0, F on carry=1; taken yields `pc_in + 2` with `taken`=1, not taken yields `pc_in` unchanged.
- R7: Long form nibble 4 is a no-operation: `pc_out` = `pc_in`, `taken` = 0, no memory read.
- R8: All PC arithmetic wraps modulo 2^16, including operand addresses.
- R9: `done` rises a fixed number of clocks after the `start` edge: 1 when no step follows, 2 for long not-taken branches and taken skips, 2+W for taken short branches and 3+2W for taken long branches, where W is the wait clocks per read.
- R10: `mem_req` stays high with a stable `mem_addr` until `mem_ack`; reads go to `pc_in` and then `pc_in+1`, and `mem_req` is only high while busy.
- R11: `start` is ignored while `busy` is high.
- R12: With `HAS_EXT_FLAGS`=0 the external flags read as all ones whatever `ext_flags` carries.
- R13: `done` is a one-clock pulse with `busy` low, and `pc_out` and `taken` change only with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an evaluation (ignored while busy) |
| is_long | input | 1 | 1 selects the long form, 0 the short form |
| nib | input | 4 | Instruction low nibble: condition and polarity |
| pc_in | input | 16 | PC pointing at the first operand byte |
| q_flag | input | 1 | Output latch state |
| acc | input | 8 | Accumulator, tested for zero |
| df_flag | input | 1 | Carry flag |
| ie_flag | input | 1 | Interrupt-enable flag |
| ext_flags | input | 4 | External sense flags, bit 0 is the first |
| mem_req | output | 1 | Byte read request |
| mem_addr | output | 16 | Byte read address |
| mem_ack | input | 1 | Read data valid this cycle |
| mem_data | input | 8 | Read data |
| busy | output | 1 | Evaluation in progress |
| done | output | 1 | One-clock result strobe |
| taken | output | 1 | Registered condition decision |
| pc_out | output | 16 | Registered next PC |

## Verification
The bound checker watches, on every clock, the read handshake (a held request with a stable address, the first read at the captured PC), the single-cycle result strobe, and the stability of the result between strobes. It also checks the fixed outcomes of a few nibbles: short never, long always, the no-operation, and the page that a taken short branch keeps. The full condition table for both forms, the operand byte order of long branches, the wrap at the top of memory, the exact latency under different read wait states, sampling at start only, a start pulse issued mid-operation, and the tied-flag build can only be shown by the bench's sweeps, which compute each result arithmetically.

// File: rtl/jt_pkg.sv
package jt_pkg;

    // number of external sense flags addressed by nib[1:0]
    localparam int NUM_EXT_FLAGS = 4;

    typedef enum logic [1:0] {
        OP_SHORT   = 2'd0,
        OP_LBRANCH = 2'd1,
        OP_LSKIP   = 2'd2,
        OP_NOP     = 2'd3
    } op_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RD_HI = 2'd1,
        ST_RD_LO = 2'd2,
        ST_STEP  = 2'd3
    } seq_state_e;

    typedef enum logic [1:0] {
        PC_KEEP = 2'd0,
        PC_INC  = 2'd1,
        PC_LOW  = 2'd2,
        PC_FULL = 2'd3
    } pc_op_e;

endpackage

// File: rtl/jt_cond_decode.sv
module jt_cond_decode
    import jt_pkg::*;
(
    input  logic                     is_long,
    input  logic [3:0]               nib,
    input  logic                     q_flag,
    input  logic                     acc_zero,
    input  logic                     df_flag,
    input  logic                     ie_flag,
    input  logic [NUM_EXT_FLAGS-1:0] flags,
    output op_kind_e                 kind,
    output logic                     cond_true
);

    logic short_raw;
    logic short_cond;
    logic long_cond;
    op_kind_e long_kind;

    // Short form: low three bits pick the test, bit 3 inverts it.
    always_comb begin
        case (nib[2:0])
            3'd0:    short_raw = 1'b1;
            3'd1:    short_raw = q_flag;
            3'd2:    short_raw = acc_zero;
            3'd3:    short_raw = df_flag;
            default: short_raw = ~flags[nib[1:0]];
        endcase
        short_cond = short_raw ^ nib[3];
    end

    // Long form: branch, skip or no-operation per nibble.
    always_comb begin
        long_kind = OP_LBRANCH;
        long_cond = 1'b0;
        case (nib)
            4'h0: begin long_kind = OP_LBRANCH; long_cond = 1'b1;      end
            4'h1: begin long_kind = OP_LBRANCH; long_cond = q_flag;    end
            4'h2: begin long_kind = OP_LBRANCH; long_cond = acc_zero;  end
            4'h3: begin long_kind = OP_LBRANCH; long_cond = df_flag;   end
            4'h4: begin long_kind = OP_NOP;     long_cond = 1'b0;      end
            4'h5: begin long_kind = OP_LSKIP;   long_cond = ~q_flag;   end
            4'h6: begin long_kind = OP_LSKIP;   long_cond = ~acc_zero; end
            4'h7: begin long_kind = OP_LSKIP;   long_cond = ~df_flag;  end
            4'h8: begin long_kind = OP_LSKIP;   long_cond = 1'b1;      end
            4'h9: begin long_kind = OP_LBRANCH; long_cond = ~q_flag;   end
            4'hA: begin long_kind = OP_LBRANCH; long_cond = ~acc_zero; end
            4'hB: begin long_kind = OP_LBRANCH; long_cond = ~df_flag;  end
            4'hC: begin long_kind = OP_LSKIP;   long_cond = ie_flag;   end
            4'hD: begin long_kind = OP_LSKIP;   long_cond = q_flag;    end
            4'hE: begin long_kind = OP_LSKIP;   long_cond = acc_zero;  end
            default: begin long_kind = OP_LSKIP; long_cond = df_flag;  end
        endcase
    end

    assign kind      = is_long ? long_kind : OP_SHORT;
    assign cond_true = is_long ? long_cond : short_cond;

endmodule

// File: rtl/jt_pc_step.sv
module jt_pc_step
    import jt_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int ADDR_W = 2 * BYTE_W
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic [BYTE_W-1:0] rd_byte,
    input  logic [BYTE_W-1:0] hi_byte,
    input  pc_op_e            op,
    output logic [ADDR_W-1:0] pc_next
);

    always_comb begin
        case (op)
            PC_INC:  pc_next = pc + ADDR_W'(1);
            PC_LOW:  pc_next = {pc[ADDR_W-1:BYTE_W], rd_byte};
            PC_FULL: pc_next = {hi_byte, rd_byte};
            default: pc_next = pc;
        endcase
    end

endmodule

// File: rtl/jump_target_unit.sv
module jump_target_unit
    import jt_pkg::*;
#(
    parameter int BYTE_W        = 8,
    parameter int HAS_EXT_FLAGS = 1,
    localparam int ADDR_W = 2 * BYTE_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     is_long,
    input  logic [3:0]               nib,
    input  logic [ADDR_W-1:0]        pc_in,
    input  logic                     q_flag,
    input  logic [BYTE_W-1:0]        acc,
    input  logic                     df_flag,
    input  logic                     ie_flag,
    input  logic [NUM_EXT_FLAGS-1:0] ext_flags,
    output logic                     mem_req,
    output logic [ADDR_W-1:0]        mem_addr,
    input  logic                     mem_ack,
    input  logic [BYTE_W-1:0]        mem_data,
    output logic                     busy,
    output logic                     done,
    output logic                     taken,
    output logic [ADDR_W-1:0]        pc_out
);

    typedef struct packed {
        seq_state_e        st;
        logic              lng;
        logic              cond;
        logic [ADDR_W-1:0] pc;
        logic [BYTE_W-1:0] hi;
        logic              done;
        logic              tk;
        logic [ADDR_W-1:0] res;
    } regs_t;

    regs_t r_d, r_q;

    logic [NUM_EXT_FLAGS-1:0] eff_flags;
    op_kind_e                 dec_kind;
    logic                     dec_true;
    pc_op_e                   step_op;
    logic [ADDR_W-1:0]        step_src;
    logic [ADDR_W-1:0]        step_out;

    generate
        if (HAS_EXT_FLAGS != 0) begin : g_ext_flags
            assign eff_flags = ext_flags;
        end else begin : g_tied_flags
            assign eff_flags = '1;
        end
    endgenerate

    jt_cond_decode i_dec (
        .is_long   (is_long),
        .nib       (nib),
        .q_flag    (q_flag),
        .acc_zero  (acc == '0),
        .df_flag   (df_flag),
        .ie_flag   (ie_flag),
        .flags     (eff_flags),
        .kind      (dec_kind),
        .cond_true (dec_true)
    );

    assign step_src = (r_q.st == ST_IDLE) ? pc_in : r_q.pc;

    jt_pc_step #(.BYTE_W(BYTE_W)) i_step (
        .pc      (step_src),
        .rd_byte (mem_data),
        .hi_byte (r_q.hi),
        .op      (step_op),
        .pc_next (step_out)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        step_op  = PC_KEEP;
        case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.lng  = is_long;
                    r_d.cond = dec_true;
                    r_d.pc   = pc_in;
                    case (dec_kind)
                        OP_SHORT: begin
                            if (dec_true) begin
                                r_d.st = ST_RD_LO;
                            end else begin
                                step_op  = PC_INC;
                                r_d.done = 1'b1;
                                r_d.res  = step_out;
                                r_d.tk   = 1'b0;
                            end
                        end
                        OP_LBRANCH: begin
                            if (dec_true) begin
                                r_d.st = ST_RD_HI;
                            end else begin
                                step_op = PC_INC;
                                r_d.pc  = step_out;
                                r_d.st  = ST_STEP;
                            end
                        end
                        OP_LSKIP: begin
                            if (dec_true) begin
                                step_op = PC_INC;
                                r_d.pc  = step_out;
                                r_d.st  = ST_STEP;
                            end else begin
                                r_d.done = 1'b1;
                                r_d.res  = pc_in;
                                r_d.tk   = 1'b0;
                            end
                        end
                        default: begin
                            r_d.done = 1'b1;
                            r_d.res  = pc_in;
                            r_d.tk   = 1'b0;
                        end
                    endcase
                end
            end
            ST_RD_HI: begin
                if (mem_ack) begin
                    r_d.hi  = mem_data;
                    step_op = PC_INC;
                    r_d.pc  = step_out;
                    r_d.st  = ST_RD_LO;
                end
            end
            ST_RD_LO: begin
                if (mem_ack) begin
                    step_op  = r_q.lng ? PC_FULL : PC_LOW;
                    r_d.res  = step_out;
                    r_d.tk   = r_q.cond;
                    r_d.done = 1'b1;
                    r_d.st   = ST_IDLE;
                end
            end
            default: begin
                step_op  = PC_INC;
                r_d.res  = step_out;
                r_d.tk   = r_q.cond;
                r_d.done = 1'b1;
                r_d.st   = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_req  = (r_q.st == ST_RD_HI) || (r_q.st == ST_RD_LO);
    assign mem_addr = r_q.pc;
    assign busy     = (r_q.st != ST_IDLE);
    assign done     = r_q.done;
    assign taken    = r_q.tk;
    assign pc_out   = r_q.res;

endmodule

// File: rtl/jump_target_unit_chk.sv
module jump_target_unit_chk #(
    parameter int BYTE_W = 8,
    localparam int ADDR_W = 2 * BYTE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              is_long,
    input logic [3:0]        nib,
    input logic [ADDR_W-1:0] pc_in,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ack,
    input logic              busy,
    input logic              done,
    input logic              taken,
    input logic [ADDR_W-1:0] pc_out
);

    logic [ADDR_W-1:0] pc_cap;
    logic              long_cap;
    logic [3:0]        nib_cap;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_cap   <= '0;
            long_cap <= 1'b0;
            nib_cap  <= '0;
        end else if (start && !busy) begin
            pc_cap   <= pc_in;
            long_cap <= is_long;
            nib_cap  <= nib;
        end
    end

    assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

    assert_first_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) |-> mem_addr == pc_cap);

    assert_req_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    assert_done_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_result_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(pc_out) && $stable(taken));

    assert_short_page_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done && !long_cap && taken |-> pc_out[ADDR_W-1:BYTE_W] == pc_cap[ADDR_W-1:BYTE_W]);

    assert_short_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done && !long_cap && !taken |-> pc_out == pc_cap + ADDR_W'(1));

    assert_short_never_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done && !long_cap && nib_cap == 4'h8 |-> !taken);

    assert_long_always_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done && long_cap && nib_cap == 4'h0 |-> taken);

    assert_nop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done && long_cap && nib_cap == 4'h4 |-> !taken && pc_out == pc_cap);

endmodule

bind jump_target_unit jump_target_unit_chk #(.BYTE_W(BYTE_W)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .is_long  (is_long),
    .nib      (nib),
    .pc_in    (pc_in),
    .mem_req  (mem_req),
    .mem_addr (mem_addr),
    .mem_ack  (mem_ack),
    .busy     (busy),
    .done     (done),
    .taken    (taken),
    .pc_out   (pc_out)
);

// File: tb/test_jump_target_unit.sv
module test_jump_target_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        is_long = 1'b0;
    logic [3:0]  nib = '0;
    logic [15:0] pc_in = '0;
    logic        q_flag = 1'b0;
    logic [7:0]  acc = '0;
    logic        df_flag = 1'b0;
    logic        ie_flag = 1'b0;
    logic [3:0]  ext_flags = '0;
    logic        mem_req;
    logic [15:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [7:0]  mem_data = '0;
    logic        busy, done, taken;
    logic [15:0] pc_out;

    // second build: external flags not wired
    logic        start_b = 1'b0;
    logic [3:0]  nib_b = '0;
    logic        mem_req_b, busy_b, done_b, taken_b;
    logic [15:0] mem_addr_b, pc_out_b;
    logic [7:0]  mem_data_b;

    int checks = 0;
    int errors = 0;
    int lat = 0;
    int wcnt = 0;
    int nacks = 0;
    logic [15:0] addr_log [2];
    longint cycles = 0;

    always #10 clk = ~clk;

    function automatic logic [7:0] mb(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
    endfunction

    jump_target_unit i_jump_target_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .is_long(is_long), .nib(nib),
        .pc_in(pc_in), .q_flag(q_flag), .acc(acc), .df_flag(df_flag),
        .ie_flag(ie_flag), .ext_flags(ext_flags), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_data(mem_data),
        .busy(busy), .done(done), .taken(taken), .pc_out(pc_out)
    );

    assign mem_data_b = mb(mem_addr_b);

    jump_target_unit #(.HAS_EXT_FLAGS(0)) i_jump_target_unit_nf (
        .clk(clk), .rst_n(rst_n), .start(start_b), .is_long(1'b0), .nib(nib_b),
        .pc_in(16'h2345), .q_flag(1'b0), .acc(8'h00), .df_flag(1'b0),
        .ie_flag(1'b0), .ext_flags(4'h0), .mem_req(mem_req_b),
        .mem_addr(mem_addr_b), .mem_ack(mem_req_b), .mem_data(mem_data_b),
        .busy(busy_b), .done(done_b), .taken(taken_b), .pc_out(pc_out_b)
    );

    // Byte memory with lat wait clocks per read; logs read addresses (R10)
    always @(negedge clk) begin
        if (mem_req) begin
            if (wcnt == lat) begin
                mem_ack  <= 1'b1;
                mem_data <= mb(mem_addr);
                wcnt     <= 0;
                if (nacks < 2) addr_log[nacks] <= mem_addr;
                nacks    <= nacks + 1;
            end else begin
                mem_ack <= 1'b0;
                wcnt    <= wcnt + 1;
            end
        end else begin
            mem_ack <= 1'b0;
            wcnt    <= 0;
        end
    end

    task automatic report;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 190000", cycles);
            report();
        end
    end

    task automatic check(input string req, input logic ok, input longint act, input longint exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Independent model of the condition table: returns class 0 short,
    // 1 long branch, 2 long skip, 3 no-op
    function automatic void model(input logic lng, input logic [3:0] n,
                                  input logic q, input logic [7:0] d, input logic df,
                                  input logic ie, input logic [3:0] ef,
                                  output int cls, output logic tk);
        logic z;
        z = (d == 8'h00);
        if (!lng) begin
            cls = 0;
            case (n)
                4'h0: tk = 1'b1;   4'h1: tk = q;      4'h2: tk = z;      4'h3: tk = df;
                4'h4: tk = !ef[0]; 4'h5: tk = !ef[1]; 4'h6: tk = !ef[2]; 4'h7: tk = !ef[3];
                4'h8: tk = 1'b0;   4'h9: tk = !q;     4'hA: tk = !z;     4'hB: tk = !df;
                4'hC: tk = ef[0];  4'hD: tk = ef[1];  4'hE: tk = ef[2];  default: tk = ef[3];
            endcase
        end else begin
            case (n)
                4'h0: begin cls = 1; tk = 1'b1; end
                4'h1: begin cls = 1; tk = q;    end
                4'h2: begin cls = 1; tk = z;    end
                4'h3: begin cls = 1; tk = df;   end
                4'h9: begin cls = 1; tk = !q;   end
                4'hA: begin cls = 1; tk = !z;   end
                4'hB: begin cls = 1; tk = !df;  end
                4'h4: begin cls = 3; tk = 1'b0; end
                4'h5: begin cls = 2; tk = !q;   end
                4'h6: begin cls = 2; tk = !z;   end
                4'h7: begin cls = 2; tk = !df;  end
                4'h8: begin cls = 2; tk = 1'b1; end
                4'hC: begin cls = 2; tk = ie;   end
                4'hD: begin cls = 2; tk = q;    end
                4'hE: begin cls = 2; tk = z;    end
                default: begin cls = 2; tk = df; end
            endcase
        end
    endfunction

    // Drive one evaluation from a negedge; flip all condition inputs after
    // the start edge (R3: only the start-cycle values count).
    task automatic run_op(input logic lng, input logic [3:0] n, input logic [15:0] pc,
                          input logic q, input logic [7:0] d, input logic df,
                          input logic ie, input logic [3:0] ef, input logic poke,
                          output logic [15:0] pcv, output logic tkv, output int cyc);
        nacks = 0;
        is_long = lng; nib = n; pc_in = pc; q_flag = q; acc = d;
        df_flag = df; ie_flag = ie; ext_flags = ef; start = 1'b1;
        @(posedge clk); @(negedge clk);
        start = 1'b0;
        q_flag = ~q; acc = (d == 8'h00) ? 8'h81 : 8'h00; df_flag = ~df;
        ie_flag = ~ie; ext_flags = ~ef;
        cyc = 1;
        while (!done && cyc < 64) begin
            if (poke && cyc == 2) begin
                // R11: a second start while busy must be ignored
                is_long = 1'b0; nib = 4'h8; pc_in = 16'h1111; start = 1'b1;
            end
            @(posedge clk); @(negedge clk);
            start = 1'b0;
            cyc = cyc + 1;
        end
        pcv = pc_out;
        tkv = taken;
    endtask

    initial begin
        logic [15:0] pcs [5];
        logic [15:0] got_pc, exp_pc, held_pc;
        logic        got_tk, exp_tk;
        int          cyc, exp_cyc, cls, idx;
        string       tag;
        pcs[0] = 16'hFFFF; pcs[1] = 16'hFFFE; pcs[2] = 16'h12FF;
        pcs[3] = 16'h0000; pcs[4] = 16'hA5C3;

        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", busy == 0 && done == 0 && mem_req == 0 && taken == 0 && pc_out == 0,
              {busy, done, mem_req, taken, pc_out}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        idx = 0;
        for (int lg = 0; lg < 2; lg++) begin
            for (int n = 0; n < 16; n++) begin
                for (int f = 0; f < 16; f++) begin
                    for (int ef = 0; ef < 16; ef++) begin
                        logic q, df, ie;
                        logic [7:0] d;
                        logic [15:0] pc;
                        q  = f[0]; df = f[1]; ie = f[2];
                        d  = f[3] ? 8'h5A : 8'h00;
                        pc = pcs[idx % 5];
                        lat = idx % 3;
                        idx = idx + 1;
                        model(lg[0], n[3:0], q, d, df, ie, ef[3:0], cls, exp_tk);
                        run_op(lg[0], n[3:0], pc, q, d, df, ie, ef[3:0], 1'b0,
                               got_pc, got_tk, cyc);
                        case (cls)
                            0: begin
                                exp_pc  = exp_tk ? {pc[15:8], mb(pc)} : pc + 16'd1;
                                exp_cyc = exp_tk ? 2 + lat : 1;
                                tag = (n[2] && n[1:0] != 2'b00) || (n >= 4 && n <= 7) || n >= 12 ? "R3" : "R2";
                                if (n == 4 || n == 12) tag = "R3";
                            end
                            1: begin
                                exp_pc  = exp_tk ? {mb(pc), mb(pc + 16'd1)} : pc + 16'd2;
                                exp_cyc = exp_tk ? 3 + 2 * lat : 2;
                                tag = "R5";
                            end
                            2: begin
                                exp_pc  = exp_tk ? pc + 16'd2 : pc;
                                exp_cyc = exp_tk ? 2 : 1;
                                tag = "R6";
                            end
                            default: begin
                                exp_pc  = pc;
                                exp_cyc = 1;
                                tag = "R7";
                            end
                        endcase
                        check(tag, got_tk == exp_tk, got_tk, exp_tk);
                        if (pc >= 16'hFFFE)
                            check("R8", got_pc == exp_pc, got_pc, exp_pc);
                        else if (cls == 0)
                            check("R4", got_pc == exp_pc, got_pc, exp_pc);
                        else
                            check(tag, got_pc == exp_pc, got_pc, exp_pc);
                        check("R9", cyc == exp_cyc, cyc, exp_cyc);
                        if (exp_tk && (cls == 0 || cls == 1)) begin
                            check("R10", addr_log[0] == pc, addr_log[0], pc);
                            if (cls == 1)
                                check("R10", addr_log[1] == pc + 16'd1, addr_log[1], pc + 16'd1);
                        end else begin
                            check("R10", nacks == 0, nacks, 0);
                        end
                        // R13: strobe lasts one clock and the result holds
                        held_pc = pc_out;
                        @(posedge clk); @(negedge clk);
                        check("R13", done == 0 && pc_out == held_pc, {done, pc_out}, {1'b0, held_pc});
                    end
                end
            end
        end

        // R11: start while busy during a taken long branch with two wait clocks
        lat = 2;
        run_op(1'b1, 4'h0, 16'h4000, 1'b0, 8'h00, 1'b0, 1'b0, 4'h0, 1'b1, got_pc, got_tk, cyc);
        check("R11", got_pc == {mb(16'h4000), mb(16'h4001)}, got_pc, {mb(16'h4000), mb(16'h4001)});
        check("R11", got_tk == 1'b1 && cyc == 7, {got_tk, cyc[7:0]}, {1'b1, 8'd7});
        @(posedge clk); @(negedge clk);
        check("R11", busy == 0 && done == 0, {busy, done}, 0);

        // R12: tied flags read as ones; ext_flags of that build is held at 0
        for (int n = 4; n < 16; n++) begin
            if (n >= 8 && n < 12) continue;
            nib_b = n[3:0];
            start_b = 1'b1;
            @(posedge clk); @(negedge clk);
            start_b = 1'b0;
            cyc = 1;
            while (!done_b && cyc < 64) begin
                @(posedge clk); @(negedge clk);
                cyc = cyc + 1;
            end
            exp_tk = n[3];
            exp_pc = exp_tk ? {8'h23, mb(16'h2345)} : 16'h2346;
            check("R12", taken_b == exp_tk, taken_b, exp_tk);
            check("R12", pc_out_b == exp_pc, pc_out_b, exp_pc);
            @(negedge clk);
        end

        report();
    end

endmodule